// File: doc/BRIEF.md
# Sectioned Register Address Sequencer

This block keeps the address for a 64-location clock and control register space that sits behind a serial-bus slave. After a start condition it waits for the bus engine to report whether the slave byte selected this space. It then takes a start address and steps the address once for each byte read or written. Each step stays inside the section that holds the current address. The block also decides, byte by byte, whether a write may land, and it flags an access that goes past the end of the one-byte status section.

The map has five sections. Two alarm banks of eight bytes sit at 00h and 08h. A four-byte control bank sits at 10h. An eight-byte time bank sits at 30h. A single status byte sits at 3Fh. The four bank bases are parameters, and so are the status address and the enable bit positions. Writes to any bank other than status are guarded by two enable bits kept in this block. Those writes are only reported as committed when a stop condition closes the operation. The register storage and the bit-level bus engine are separate blocks. They consume `reg_addr`, `addr_defined`, `wr_permit`, `terminate` and `wr_commit`.

Top module: `ccr_addr_seq`

## Requirements
- R1: After reset the block is idle, `reg_addr` is 00h, and `wr_permit`, `terminate` and `wr_commit` are all 0.
- R2: After `bus_start`, a `sel_ok` pulse makes the block active. If `scl_tick` pulses 9 times with no `sel_ok`, the block returns to idle and ignores a later `sel_ok` until the next start. After only 8 ticks, `sel_ok` is still accepted.
- R3: While the block is active, `addr_load` copies `addr_in` into `reg_addr`. Any of the 64 addresses may be loaded.
- R4: Each `rd_byte` or `wr_byte` while active advances `reg_addr` by one and wraps inside its section. The sections are 00h-07h, 08h-0Fh, 10h-13h and 30h-37h.
- R5: At the status address 3Fh, the first byte access is accepted. A second access raises `terminate`, leaves `reg_addr` unchanged and drops `wr_permit`. These conditions hold until the next start or stop.
- R6: A write to the status byte updates the enable bits. The first-stage enable is bit 1 and the second-stage enable is bit 2. The first-stage enable takes data bit 1. The second-stage enable is set only when data bits 1 and 2 are both 1 and the first-stage enable was already set; every other status write clears it. `wr_permit` for a non-status address needs both enables set.
- R7: `wr_commit` pulses for one cycle after a `bus_stop` that closes an operation in which at least one permitted non-status write occurred. A `bus_start` before that stop discards the pending write.
- R8: After a stop, `reg_addr` keeps the address that follows the last byte. A new operation with no `addr_load` continues from there.
- R9: Addresses outside every section give `addr_defined` = 0 and `wr_permit` = 0. They advance by one, modulo 64.
- R10: The first write to the status byte is permitted with both enables clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | Start condition seen (pulse) |
| bus_stop | input | 1 | Stop condition seen (pulse) |
| scl_tick | input | 1 | One pulse per serial clock while waiting for the slave byte |
| sel_ok | input | 1 | Slave byte matched this register space (pulse) |
| addr_load | input | 1 | Start address byte received (pulse) |
| addr_in | input | 6 | Start address |
| rd_byte | input | 1 | One data byte read (pulse) |
| wr_byte | input | 1 | One data byte written (pulse) |
| wr_data | input | 8 | Data of the byte written |
| reg_addr | output | 6 | Current register address |
| addr_defined | output | 1 | Current address lies in a section |
| wr_permit | output | 1 | A write at the current address is allowed |
| terminate | output | 1 | Access continued past the status byte |
| wr_commit | output | 1 | Pending section writes take effect (pulse) |

## Verification
Every result is registered, so `reg_addr`, `terminate`, `wr_commit` and the enable state change on the first rising edge after the strobe that causes them. `wr_permit` follows that same registered state with no further delay. The bench drives each strobe for exactly one cycle from the falling edge. It reads the outputs at the next falling edge, which is one edge after the strobe. For example, `wr_commit` is sampled in the falling edge where `bus_stop` is being released. The select timeout is measured by tick count and not by cycle count: 8 ticks followed by `sel_ok` must succeed, and 9 ticks must fail.

// File: rtl/ccr_seq_pkg.sv
package ccr_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SELECT = 2'd1,
      ST_ACTIVE = 2'd2,
      ST_TERM   = 2'd3
   } seq_state_t;

   localparam int NUM_SECT  = 5;
   localparam int SECT_STAT = 4;
endpackage

// File: rtl/ccr_sect_decode.sv
module ccr_sect_decode #(
   parameter int ADDR_W    = 6,
   parameter int AL0_BASE  = 0,
   parameter int AL1_BASE  = 8,
   parameter int CTL_BASE  = 16,
   parameter int RTC_BASE  = 48,
   parameter int STAT_ADDR = 63
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              defined,
   output logic              is_status,
   output logic [ADDR_W-1:0] next_addr
);
   import ccr_seq_pkg::*;

   localparam int SIZES [NUM_SECT] = '{8, 8, 4, 8, 1};
   localparam int BASES [NUM_SECT] = '{AL0_BASE, AL1_BASE, CTL_BASE, RTC_BASE, STAT_ADDR};

   logic [NUM_SECT-1:0] hit;
   logic [ADDR_W-1:0]   nxt [NUM_SECT];
   logic [ADDR_W-1:0]   step;

   assign step = addr + 1'b1;

   for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
      localparam logic [ADDR_W-1:0] MASK = ADDR_W'(SIZES[i] - 1);
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASES[i]);

      if ((BASES[i] % SIZES[i]) != 0) begin : g_bad_align
         $error("section %0d base not aligned to its size", i);
      end
      if (BASES[i] + SIZES[i] > (1 << ADDR_W)) begin : g_bad_range
         $error("section %0d exceeds the address space", i);
      end
      for (genvar j = i + 1; j < NUM_SECT; j++) begin : g_ovl
         if ((BASES[i] < BASES[j] + SIZES[j]) && (BASES[j] < BASES[i] + SIZES[i])) begin : g_bad_ovl
            $error("sections %0d and %0d overlap", i, j);
         end
      end

      assign hit[i] = ((addr & ~MASK) == BASE);
      assign nxt[i] = (addr & ~MASK) | (step & MASK);
   end

   always_comb begin
      next_addr = step;
      for (int k = 0; k < NUM_SECT; k++) begin
         if (hit[k]) next_addr = nxt[k];
      end
   end

   assign defined   = |hit;
   assign is_status = hit[SECT_STAT];
endmodule

// File: rtl/ccr_sel_timer.sv
module ccr_sel_timer #(
   parameter int LIMIT = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   input  logic tick,
   output logic expire
);
   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (clear)         cnt_q <= '0;
      else if (run && tick)   cnt_q <= cnt_q + 1'b1;
   end

   assign expire = run && tick && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/ccr_wr_enable.sv
module ccr_wr_enable #(
   parameter int DATA_W   = 8,
   parameter int WEL_BIT  = 1,
   parameter int RWEL_BIT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [DATA_W-1:0] data,
   output logic              wel,
   output logic              rwel
);
   if (WEL_BIT >= DATA_W || RWEL_BIT >= DATA_W || WEL_BIT == RWEL_BIT) begin : g_bad_bits
      $error("enable bit positions invalid");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel  <= 1'b0;
         rwel <= 1'b0;
      end else if (upd) begin
         wel  <= data[WEL_BIT];
         rwel <= data[WEL_BIT] && data[RWEL_BIT] && wel;
      end
   end
endmodule

// File: rtl/ccr_addr_seq.sv
module ccr_addr_seq #(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 8,
   parameter int AL0_BASE  = 0,
   parameter int AL1_BASE  = 8,
   parameter int CTL_BASE  = 16,
   parameter int RTC_BASE  = 48,
   parameter int STAT_ADDR = 63,
   parameter int SEL_TICKS = 9,
   parameter int WEL_BIT   = 1,
   parameter int RWEL_BIT  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic              scl_tick,
   input  logic              sel_ok,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              rd_byte,
   input  logic              wr_byte,
   input  logic [DATA_W-1:0] wr_data,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              addr_defined,
   output logic              wr_permit,
   output logic              terminate,
   output logic              wr_commit
);
   import ccr_seq_pkg::*;

   seq_state_t        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] next_addr;
   logic              touched_q;
   logic              pending_q;
   logic              commit_q;
   logic              is_status;
   logic              wel, rwel;
   logic              active;
   logic              quiet;
   logic              expire;
   logic              access;
   logic              en_upd;

   ccr_sect_decode #(
      .ADDR_W(ADDR_W), .AL0_BASE(AL0_BASE), .AL1_BASE(AL1_BASE),
      .CTL_BASE(CTL_BASE), .RTC_BASE(RTC_BASE), .STAT_ADDR(STAT_ADDR)
   ) u_decode (
      .addr(addr_q), .defined(addr_defined), .is_status(is_status), .next_addr(next_addr)
   );

   ccr_sel_timer #(.LIMIT(SEL_TICKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .clear(bus_start),
      .run(state_q == ST_SELECT && !sel_ok && quiet),
      .tick(scl_tick), .expire(expire)
   );

   ccr_wr_enable #(.DATA_W(DATA_W), .WEL_BIT(WEL_BIT), .RWEL_BIT(RWEL_BIT)) u_enable (
      .clk(clk), .rst_n(rst_n), .upd(en_upd), .data(wr_data), .wel(wel), .rwel(rwel)
   );

   assign active = (state_q == ST_ACTIVE);
   assign quiet  = !bus_start && !bus_stop;
   assign access = active && quiet && !addr_load && (rd_byte || wr_byte);
   assign en_upd = access && wr_byte && is_status && !touched_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         addr_q    <= '0;
         touched_q <= 1'b0;
         pending_q <= 1'b0;
         commit_q  <= 1'b0;
      end else begin
         commit_q <= 1'b0;
         if (bus_start) begin
            state_q   <= ST_SELECT;
            touched_q <= 1'b0;
            pending_q <= 1'b0;
         end else if (bus_stop) begin
            state_q   <= ST_IDLE;
            touched_q <= 1'b0;
            pending_q <= 1'b0;
            commit_q  <= pending_q;
         end else begin
            unique case (state_q)
               ST_SELECT: begin
                  if (sel_ok) begin
                     state_q   <= ST_ACTIVE;
                     touched_q <= 1'b0;
                  end else if (expire) begin
                     state_q   <= ST_IDLE;
                  end
               end
               ST_ACTIVE: begin
                  if (addr_load) begin
                     addr_q    <= addr_in;
                     touched_q <= 1'b0;
                  end else if (access) begin
                     if (is_status && touched_q) begin
                        state_q <= ST_TERM;
                     end else begin
                        addr_q    <= next_addr;
                        touched_q <= 1'b1;
                        if (wr_byte && wr_permit && !is_status) pending_q <= 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign reg_addr  = addr_q;
   assign wr_permit = active && addr_defined && (is_status ? !touched_q : (wel && rwel));
   assign terminate = (state_q == ST_TERM);
   assign wr_commit = commit_q;
endmodule

// File: rtl/ccr_addr_seq_chk.sv
module ccr_addr_seq_chk #(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_start,
   input logic              bus_stop,
   input logic              rd_byte,
   input logic              wr_byte,
   input logic              addr_load,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              addr_defined,
   input logic              wr_permit,
   input logic              terminate,
   input logic              wr_commit,
   input logic              wel,
   input logic              rwel,
   input logic              is_status,
   input logic              active
);
   // R5: no write while terminated
   a_r5_term_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
      terminate |-> !wr_permit);

   // R5: terminate and address hold until start or stop
   a_r5_term_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (terminate && !bus_start && !bus_stop) |=> (terminate && $stable(reg_addr)));

   // R6: section writes need both enables
   a_r6_permit_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_permit && !is_status) |-> (wel && rwel));

   // R6: second stage never set alone
   a_r6_rwel_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      rwel |-> wel);

   // R7: commit only follows a stop
   a_r7_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> $past(bus_stop));

   // R4: stepping never leaves a defined section
   a_r4_stay_in_section: assert property (@(posedge clk) disable iff (!rst_n)
      (active && addr_defined && (rd_byte || wr_byte) && !addr_load && !bus_start && !bus_stop)
      |=> addr_defined);

   // R9: undefined addresses are never writable
   a_r9_undefined_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_defined |-> !wr_permit);
endmodule

bind ccr_addr_seq ccr_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
   .rd_byte(rd_byte), .wr_byte(wr_byte), .addr_load(addr_load),
   .reg_addr(reg_addr), .addr_defined(addr_defined), .wr_permit(wr_permit),
   .terminate(terminate), .wr_commit(wr_commit), .wel(wel), .rwel(rwel),
   .is_status(is_status), .active(active)
);

// File: tb/ccr_addr_seq_bench.sv
module ccr_addr_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_start = 0, bus_stop = 0, scl_tick = 0, sel_ok = 0;
   logic       addr_load = 0, rd_byte = 0, wr_byte = 0;
   logic [5:0] addr_in = '0;
   logic [7:0] wr_data = '0;
   logic [5:0] reg_addr;
   logic       addr_defined, wr_permit, terminate, wr_commit;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 0;

   always #4 clk = ~clk;

   ccr_addr_seq u_ccr_addr_seq (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
      .scl_tick(scl_tick), .sel_ok(sel_ok), .addr_load(addr_load), .addr_in(addr_in),
      .rd_byte(rd_byte), .wr_byte(wr_byte), .wr_data(wr_data),
      .reg_addr(reg_addr), .addr_defined(addr_defined), .wr_permit(wr_permit),
      .terminate(terminate), .wr_commit(wr_commit)
   );

   // {start address, byte count, expected address}
   localparam logic [15:0] VECS [8] = '{
      {6'h05, 4'd5, 6'h02}, {6'h0F, 4'd1, 6'h08}, {6'h12, 4'd3, 6'h11},
      {6'h36, 4'd4, 6'h32}, {6'h20, 4'd3, 6'h23}, {6'h3E, 4'd1, 6'h3F},
      {6'h3F, 4'd1, 6'h3F}, {6'h17, 4'd2, 6'h19}
   };

   function automatic bit in_section(input logic [5:0] a);
      return (a < 6'h14) || (a >= 6'h30 && a < 6'h38) || (a == 6'h3F);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic pulse_start();
      bus_start = 1; step(); bus_start = 0;
   endtask
   task automatic pulse_sel();
      sel_ok = 1; step(); sel_ok = 0;
   endtask
   task automatic pulse_tick();
      scl_tick = 1; step(); scl_tick = 0;
   endtask
   task automatic load(input logic [5:0] a);
      addr_in = a; addr_load = 1; step(); addr_load = 0;
   endtask
   task automatic rd();
      rd_byte = 1; step(); rd_byte = 0;
   endtask
   task automatic wr(input logic [7:0] d);
      wr_data = d; wr_byte = 1; step(); wr_byte = 0;
   endtask
   task automatic stop_and_check_commit(input string req, input int exp);
      bus_stop = 1; step(); chk(req, wr_commit, exp); bus_stop = 0;
   endtask
   task automatic open_op(input logic [5:0] a);
      pulse_start(); pulse_sel(); load(a);
   endtask

   initial begin
      repeat (3) step();
      chk("R1 reg_addr", reg_addr, 0);
      chk("R1 wr_permit", wr_permit, 0);
      chk("R1 terminate", terminate, 0);
      chk("R1 wr_commit", wr_commit, 0);
      rst_n = 1; step();

      // R3 R4 R9 table of section walks
      for (int i = 0; i < 8; i++) begin
         open_op(VECS[i][15:10]);
         chk("R3 loaded address", reg_addr, VECS[i][15:10]);
         for (int b = 0; b < int'(VECS[i][9:6]); b++) rd();
         chk("R4 wrapped address", reg_addr, VECS[i][5:0]);
         chk("R9 addr_defined", addr_defined, in_section(VECS[i][5:0]));
         bus_stop = 1; step(); bus_stop = 0;
      end

      // R8 current-address continuation
      open_op(6'h10); rd(); rd();
      bus_stop = 1; step(); bus_stop = 0;
      chk("R8 held after stop", reg_addr, 6'h12);
      pulse_start(); pulse_sel(); rd();
      chk("R8 continued address", reg_addr, 6'h13);
      bus_stop = 1; step(); bus_stop = 0;

      // R9 undefined address not writable, wraps modulo 64
      open_op(6'h2F);
      chk("R9 undefined wr_permit", wr_permit, 0);
      open_op(6'h3F); bus_stop = 1; step(); bus_stop = 0;

      // R5 status terminate
      open_op(6'h3F);
      chk("R10 status permit without enables", wr_permit, 1);
      rd();
      chk("R5 first status access", terminate, 0);
      rd();
      chk("R5 terminate raised", terminate, 1);
      chk("R5 address unchanged", reg_addr, 6'h3F);
      chk("R5 wr_permit dropped", wr_permit, 0);
      wr(8'h06);
      chk("R5 terminate held", terminate, 1);
      bus_stop = 1; step(); bus_stop = 0;
      chk("R5 cleared by stop", terminate, 0);

      // R6 one-step write of both bits does not enable
      open_op(6'h3F); wr(8'h06); load(6'h00);
      chk("R6 one-step not enabled", wr_permit, 0);
      bus_stop = 1; step(); bus_stop = 0;
      // now first stage is set; second step enables
      open_op(6'h3F); wr(8'h06); load(6'h00);
      chk("R6 two-step enabled", wr_permit, 1);
      wr(8'hAA);
      chk("R4 write advances", reg_addr, 6'h01);
      stop_and_check_commit("R7 commit on stop", 1);
      step();
      chk("R7 commit one cycle", wr_commit, 0);

      // R7 abort by repeated start
      open_op(6'h09); wr(8'h11);
      pulse_start();
      stop_and_check_commit("R7 aborted by start", 0);

      // R6 other status write clears second stage
      open_op(6'h3F); wr(8'h02); load(6'h0A);
      chk("R6 cleared by other write", wr_permit, 0);
      wr(8'h33);
      stop_and_check_commit("R7 no commit without permit", 0);

      // R2 select timeout: 8 ticks still accepted
      pulse_start();
      for (int t = 0; t < 8; t++) pulse_tick();
      pulse_sel(); load(6'h3F);
      chk("R2 accepted after 8 ticks", wr_permit, 1);
      bus_stop = 1; step(); bus_stop = 0;
      // 9 ticks returns to idle; later sel_ok ignored (held address 3Fh)
      pulse_start();
      for (int t = 0; t < 9; t++) pulse_tick();
      pulse_sel();
      chk("R2 idle after 9 ticks", wr_permit, 0);
      rd();
      chk("R2 address untouched when idle", reg_addr, 6'h3F);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule